// File: doc/BRIEF.md
# Fractional baud clock prescaler

This block sits in front of a UART baud-rate divider and thins the input clock into a train of single-cycle enable pulses. In bypass mode a pulse is issued on every input cycle. In fractional mode the pulses arrive at an average rate of the input rate divided by M + N/8. M and N come from an 8-bit ratio register that software may always write.

A select flag chooses between bypass and fractional mode. During reset the flag is loaded with the complement of a strap pin. Software may write the flag afterwards, but such a write is accepted only while enhanced mode is asserted.

Both the ratio register and the flag are shadowed. A written value reaches the divider at the next output pulse, so a pulse period in progress is never cut short. When a new setting is applied, the accumulator restarts from zero.

Top module: `frac_prescaler`

## Requirements
- R1: While the applied select flag is 0, `tick_o` is high on every input cycle.
- R2: While the applied select flag is 1, with the ratio register holding M in bits [7:3] and N in bits [2:0], `tick_o` pulses exactly 8 times in every window of 8M+N consecutive cycles.
- R3: In fractional mode, two successive pulses are separated by either floor((8M+N)/8) or ceil((8M+N)/8) cycles.
- R4: An M field of 0 behaves exactly as an M field of 1.
- R5: After reset, `ratio_o` reads 0x20, and with the flag set the pulse rate is one in every 4 cycles.
- R6: During reset, the select flag `sel_o` takes the complement of `fast_strap_i`.
- R7: A flag write (`sel_wr_i`) made while `enh_mode_i` is 0 leaves `sel_o` and the pulse rate unchanged. While `enh_mode_i` is 1, `sel_o` equals the written bit on the next cycle. A ratio write is shown on `ratio_o` on the next cycle, whatever the mode.
- R8: A newly written ratio or flag value takes effect only at the first output pulse after the write. Pulses in progress keep the old spacing until then.
- R9: When a changed setting is applied, the accumulator clears. The first gap after that pulse is therefore ceil((8M+N)/8) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fast_strap_i | input | 1 | Strap pin; the flag resets to its complement |
| enh_mode_i | input | 1 | Enhanced mode; enables flag writes |
| sel_wr_i | input | 1 | Flag write strobe |
| sel_wdata_i | input | 1 | Flag write value (1 = fractional) |
| ratio_wr_i | input | 1 | Ratio register write strobe |
| ratio_wdata_i | input | 8 | Ratio write value, M in [7:3], N in [2:0] |
| sel_o | output | 1 | Software-visible select flag |
| ratio_o | output | 8 | Software-visible ratio register |
| tick_o | output | 1 | Clock-enable pulse |

## Verification
The bench uses the default parameters: an 8-bit ratio with 3 fraction bits and a reset ratio of 0x20. With these values every limit from 8 to 255 can be reached, including the ratios 0x00 and 0x03 where M is 0 and the longest setting, 0xFF. Because the longest pulse period is only 32 cycles, complete windows of 8M+N cycles and the boundary delay after a write can both be measured in a short run. The strap pin is exercised at both levels by resetting the block twice.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int RATIO_W = 8;
  localparam int FRAC_W  = 3;
  localparam int INT_W   = RATIO_W - FRAC_W;
  localparam int ACC_W   = RATIO_W + 1;
  localparam int STEP    = 1 << FRAC_W;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [ACC_W-1:0]   acc_t;
endpackage

// File: rtl/fps_cfg_regs.sv
module fps_cfg_regs
  import fps_pkg::*;
#(
  parameter ratio_t RESET_RATIO = 8'h20
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   strap_i,
  input  logic   enh_i,
  input  logic   sel_wr_i,
  input  logic   sel_wdata_i,
  input  logic   ratio_wr_i,
  input  ratio_t ratio_wdata_i,
  input  logic   tick_i,
  output logic   sel_o,
  output ratio_t ratio_o,
  output logic   act_sel_o,
  output ratio_t act_ratio_o,
  output logic   reload_o
);
  logic   sel_q, act_sel_q;
  ratio_t ratio_q, act_ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= ~strap_i;
      ratio_q <= RESET_RATIO;
    end else begin
      if (sel_wr_i && enh_i) sel_q <= sel_wdata_i;
      if (ratio_wr_i)        ratio_q <= ratio_wdata_i;
    end
  end

  // shadow copy, refreshed only on a pulse boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sel_q   <= ~strap_i;
      act_ratio_q <= RESET_RATIO;
    end else if (tick_i) begin
      act_sel_q   <= sel_q;
      act_ratio_q <= ratio_q;
    end
  end

  assign reload_o    = tick_i && ((sel_q != act_sel_q) || (ratio_q != act_ratio_q));
  assign sel_o       = sel_q;
  assign ratio_o     = ratio_q;
  assign act_sel_o   = act_sel_q;
  assign act_ratio_o = act_ratio_q;
endmodule

// File: rtl/fps_limit.sv
module fps_limit
  import fps_pkg::*;
(
  input  ratio_t ratio_i,
  output ratio_t lim_o
);
  logic [INT_W-1:0] m_raw, m_eff;

  assign m_raw = ratio_i[RATIO_W-1:FRAC_W];
  assign m_eff = (m_raw == '0) ? INT_W'(1) : m_raw;
  // 8*M + N is the fields placed side by side
  assign lim_o = {m_eff, ratio_i[FRAC_W-1:0]};
endmodule

// File: rtl/fps_accum.sv
module fps_accum
  import fps_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   frac_en_i,
  input  ratio_t lim_i,
  input  logic   clr_i,
  output logic   tick_o,
  output acc_t   acc_o
);
  acc_t acc_q, acc_nxt, lim_ext;
  logic hit;

  assign lim_ext = {1'b0, lim_i};
  assign acc_nxt = acc_q + ACC_W'(STEP);
  assign hit     = acc_nxt >= lim_ext;
  assign tick_o  = !frac_en_i || hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  acc_q <= '0;
    else if (clr_i || !frac_en_i) acc_q <= '0;
    else if (hit)                 acc_q <= acc_nxt - lim_ext;
    else                          acc_q <= acc_nxt;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler
  import fps_pkg::*;
#(
  parameter ratio_t RESET_RATIO = 8'h20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fast_strap_i,
  input  logic               enh_mode_i,
  input  logic               sel_wr_i,
  input  logic               sel_wdata_i,
  input  logic               ratio_wr_i,
  input  logic [RATIO_W-1:0] ratio_wdata_i,
  output logic               sel_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               tick_o
);
  logic   act_sel, reload;
  ratio_t act_ratio, lim;
  acc_t   acc;

  fps_cfg_regs #(.RESET_RATIO(RESET_RATIO)) u_cfg (
    .clk_i, .rst_ni,
    .strap_i       (fast_strap_i),
    .enh_i         (enh_mode_i),
    .sel_wr_i, .sel_wdata_i, .ratio_wr_i, .ratio_wdata_i,
    .tick_i        (tick_o),
    .sel_o, .ratio_o,
    .act_sel_o     (act_sel),
    .act_ratio_o   (act_ratio),
    .reload_o      (reload)
  );

  fps_limit u_lim (
    .ratio_i (act_ratio),
    .lim_o   (lim)
  );

  fps_accum u_acc (
    .clk_i, .rst_ni,
    .frac_en_i (act_sel),
    .lim_i     (lim),
    .clr_i     (reload),
    .tick_o,
    .acc_o     (acc)
  );
endmodule

// File: rtl/frac_prescaler_chk.sv
module frac_prescaler_chk
  import fps_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   enh_mode_i,
  input logic   sel_wr_i,
  input logic   sel_wdata_i,
  input logic   ratio_wr_i,
  input ratio_t ratio_wdata_i,
  input logic   sel_o,
  input ratio_t ratio_o,
  input logic   tick_o,
  input logic   act_sel_i,
  input ratio_t act_ratio_i,
  input acc_t   acc_i,
  input ratio_t lim_i
);
  assert_bypass_every_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_sel_i |-> tick_o);

  assert_acc_below_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_sel_i |-> (acc_i < {1'b0, lim_i}));

  assert_limit_min_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_i >= ratio_t'(STEP));

  assert_flag_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && !enh_mode_i) |=> $stable(sel_o));

  assert_flag_write_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && enh_mode_i) |=> (sel_o == $past(sel_wdata_i)));

  assert_ratio_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_wr_i |=> (ratio_o == $past(ratio_wdata_i)));

  assert_hold_between_pulses_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> ($stable(act_sel_i) && $stable(act_ratio_i)));

  assert_clear_on_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && act_sel_i && ((act_ratio_i != ratio_o) || (act_sel_i != sel_o)) && sel_o) |=> (acc_i == '0));
endmodule

bind frac_prescaler frac_prescaler_chk u_chk (
  .clk_i, .rst_ni, .enh_mode_i, .sel_wr_i, .sel_wdata_i, .ratio_wr_i, .ratio_wdata_i,
  .sel_o, .ratio_o, .tick_o,
  .act_sel_i   (act_sel),
  .act_ratio_i (act_ratio),
  .acc_i       (acc),
  .lim_i       (lim)
);

// File: tb/sim_frac_prescaler.sv
module sim_frac_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {ratio, expected limit 8*max(M,1)+N}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h20, 8'd32}, {8'h0C, 8'd12}, {8'h0D, 8'd13}, {8'hFF, 8'd255}, {8'h08, 8'd8},
    {8'h03, 8'd11}, {8'h00, 8'd8},  {8'h19, 8'd25}, {8'h27, 8'd39}
  };

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0, enh = 1'b0;
  logic sel_wr = 1'b0, sel_wd = 1'b0, ratio_wr = 1'b0;
  logic [7:0] ratio_wd = '0;
  logic sel, tick;
  logic [7:0] ratio;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_prescaler u0 (
    .clk_i(clk), .rst_ni(rst_n), .fast_strap_i(strap), .enh_mode_i(enh),
    .sel_wr_i(sel_wr), .sel_wdata_i(sel_wd), .ratio_wr_i(ratio_wr), .ratio_wdata_i(ratio_wd),
    .sel_o(sel), .ratio_o(ratio), .tick_o(tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    strap = s; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_ratio(input logic [7:0] v);
    @(negedge clk); ratio_wr = 1'b1; ratio_wd = v;
    @(negedge clk); ratio_wr = 1'b0;
  endtask

  task automatic wr_sel(input logic v);
    @(negedge clk); sel_wr = 1'b1; sel_wd = v;
    @(negedge clk); sel_wr = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) c++;
    end
  endtask

  task automatic gap_range(input int n, output int gmin, output int gmax);
    int prev;
    prev = -1; gmin = 1 << 20; gmax = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) begin
        if (prev >= 0) begin
          if (i - prev < gmin) gmin = i - prev;
          if (i - prev > gmax) gmax = i - prev;
        end
        prev = i;
      end
    end
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int c, gmin, gmax, lim;
    // reset state, strap low
    do_reset(1'b0);
    @(negedge clk);
    chk("R6 flag after reset strap=0", sel, 1);
    chk("R5 ratio after reset", ratio, 8'h20);
    count_ticks(32, c);
    chk("R5 divide-by-4 after reset", c, 8);

    // flag write outside enhanced mode is ignored
    enh = 1'b0;
    wr_sel(1'b0);
    @(negedge clk);
    chk("R7 flag unchanged without enh", sel, 1);
    repeat (40) @(negedge clk);
    count_ticks(32, c);
    chk("R7 rate unchanged without enh", c, 8);

    // table of ratios
    for (int v = 0; v < NVEC; v++) begin
      wr_ratio(VEC[v][15:8]);
      @(negedge clk);
      chk("R7 ratio readback", ratio, VEC[v][15:8]);
      lim = VEC[v][7:0];
      repeat (80) @(negedge clk);
      count_ticks(lim, c);
      chk((VEC[v][15:11] == 0) ? "R4 pulses per window M=0" : "R2 pulses per window", c, 8);
      gap_range(2 * lim + 2, gmin, gmax);
      chk("R3 min gap", gmin, lim / 8);
      chk("R3 max gap", gmax, (lim + 7) / 8);
    end

    // R8: new ratio waits for the next pulse
    wr_ratio(8'hFF);
    repeat (80) @(negedge clk);
    wait_tick();
    ratio_wr = 1'b1; ratio_wd = 8'h08;
    @(negedge clk); ratio_wr = 1'b0;
    c = tick ? 1 : 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (tick) c++;
    end
    chk("R8 old spacing kept until boundary", c, 0);
    repeat (20) @(negedge clk);
    count_ticks(16, c);
    chk("R8 new ratio after boundary", c, 16);

    // R9: accumulator restarts when a new ratio is applied
    wr_ratio(8'h27);
    repeat (100) @(negedge clk);
    wr_ratio(8'h20);
    wait_tick();
    c = 0;
    do begin @(negedge clk); c++; end while (!tick);
    chk("R9 first gap after reload", c, 4);

    // enhanced mode: flag write accepted
    enh = 1'b1;
    wr_sel(1'b0);
    @(negedge clk);
    chk("R7 flag written in enh", sel, 0);
    repeat (40) @(negedge clk);
    count_ticks(20, c);
    chk("R1 bypass every cycle", c, 20);

    // reset with strap high
    do_reset(1'b1);
    @(negedge clk);
    chk("R6 flag after reset strap=1", sel, 0);
    count_ticks(16, c);
    chk("R1 bypass after strap reset", c, 16);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule